// File: doc/BRIEF.md
# Per-Level Queue Depth Interrupt

This block tracks how many entries sit in each of several priority levels of a work input queue, without holding the entries themselves. Every cycle it may see one enqueue strobe and one dequeue strobe, each tagged with a level index. It moves that level's depth counter up or down by one, and it keeps a combined depth across all levels. The queue storage and the bus that carries the strobes belong to the surrounding design.

Software programs a depth threshold for each level and a per-level enable mask through a small register port. A level's sticky status bit is set when that level's depth moves and the new depth equals the threshold exactly. The trigger is an event on arrival at the value, not a comparison of levels. One interrupt output combines the enabled status bits. A dequeue aimed at an empty level is dropped and recorded in a sticky error flag.

Top module: `qdepth_irq`

## Requirements
- R1: After reset every depth counter, the combined depth, every threshold, the enable mask, all status bits, the error flag and `irq` are zero.
- R2: An enqueue strobe alone on level L makes that level's depth one higher in the cycle after the strobe.
- R3: A dequeue strobe alone on a non-empty level L makes that level's depth one lower in the cycle after the strobe.
- R4: An enqueue and a dequeue on the same level in the same cycle leave that level's depth unchanged and set no status bit.
- R5: A dequeue on an empty level, without an enqueue on that level in the same cycle, leaves the depth at zero and sets the sticky error flag. The flag is bit 0 of misc register 3 and is cleared by writing 1 to that bit.
- R6: The combined depth, readable at misc register 0, always equals the sum of all level depths.
- R7: Status bit L is set when the depth of level L changes, in either direction, and the new depth equals threshold L. A threshold write, or a cycle in which the depth does not change, never sets it. Status sits at misc register 2, one bit per level.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R9: If a status bit or the error flag is set and cleared in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some level has both its status bit and its enable bit set. The enable mask is misc register 1, one bit per level.
- R11: Address map. The top two address bits select a region: 0 for depths, 1 for thresholds, 2 for misc, 3 for a spare region that reads zero. The low bits select the level or the misc register. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_level | input | LVL_W | Level of the enqueue |
| deq_valid | input | 1 | Dequeue strobe |
| deq_level | input | LVL_W | Level of the dequeue |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | LVL_W+2 | Register address (region, index) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with eight levels, 6-bit level depths and a 9-bit combined depth. Small depths keep the threshold values a few strobes away, so arrival by increment and arrival by decrement can both be reached quickly. The 9-bit combined depth still holds the sum of all eight levels at their maximum. Eight levels make the address map five bits wide. Every region is then decoded, including the spare one.

// File: rtl/qdepth_pkg.sv
package qdepth_pkg;

    typedef enum logic [1:0] {
        RGN_COUNT  = 2'd0,
        RGN_THRESH = 2'd1,
        RGN_MISC   = 2'd2,
        RGN_SPARE  = 2'd3
    } region_e;

    localparam int unsigned MISC_TOTAL  = 0;
    localparam int unsigned MISC_ENABLE = 1;
    localparam int unsigned MISC_STATUS = 2;
    localparam int unsigned MISC_ERROR  = 3;

    function automatic int widest(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/qdepth_level.sv
module qdepth_level #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [CNT_W-1:0] thr,
    input  logic             clr_stat,
    output logic [CNT_W-1:0] cnt,
    output logic             stat,
    output logic             dec_taken,
    output logic             underflow
);
    logic             empty;
    logic             up;
    logic             down;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    assign empty     = (cnt == '0);
    assign up        = inc & ~dec;
    assign down      = dec & ~inc & ~empty;
    assign dec_taken = dec & (inc | ~empty);
    assign underflow = dec & ~inc & empty;

    always_comb begin
        cnt_nxt = cnt;
        if (up) begin
            cnt_nxt = cnt + CNT_W'(1);
        end else if (down) begin
            cnt_nxt = cnt - CNT_W'(1);
        end
    end

    // Event trigger: only a moving count that lands on the threshold.
    assign hit = (up | down) && (cnt_nxt == thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            stat <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (hit) begin
                stat <= 1'b1;
            end else if (clr_stat) begin
                stat <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qdepth_total.sv
module qdepth_total #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [TOT_W-1:0] tot
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot <= '0;
        end else if (inc && !dec) begin
            tot <= tot + TOT_W'(1);
        end else if (dec && !inc) begin
            tot <= tot - TOT_W'(1);
        end
    end

endmodule

// File: rtl/qdepth_regs.sv
module qdepth_regs
    import qdepth_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int CNT_W      = 32,
    parameter int TOT_W      = 32,
    parameter int LVL_W      = 3,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 reg_wen,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic [DATA_W-1:0]                    reg_wdata,
    input  logic [NUM_LEVELS-1:0][CNT_W-1:0]     cnt_vec,
    input  logic [TOT_W-1:0]                     tot,
    input  logic [NUM_LEVELS-1:0]                stat_vec,
    input  logic                                 underflow_any,
    output logic [NUM_LEVELS-1:0][CNT_W-1:0]     thr_vec,
    output logic [NUM_LEVELS-1:0]                enable,
    output logic [NUM_LEVELS-1:0]                clr_vec,
    output logic                                 err_flag,
    output logic [DATA_W-1:0]                    reg_rdata
);
    region_e          region;
    logic [LVL_W-1:0] idx;
    logic             idx_ok;
    logic             misc_wr;

    assign region  = region_e'(reg_addr[ADDR_W-1:LVL_W]);
    assign idx     = reg_addr[LVL_W-1:0];
    assign idx_ok  = (int'(idx) < NUM_LEVELS);
    assign misc_wr = reg_wen && (region == RGN_MISC);

    assign clr_vec = (misc_wr && idx == LVL_W'(MISC_STATUS))
                   ? reg_wdata[NUM_LEVELS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_vec  <= '0;
            enable   <= '0;
            err_flag <= 1'b0;
        end else begin
            if (reg_wen && region == RGN_THRESH && idx_ok) begin
                thr_vec[idx] <= reg_wdata[CNT_W-1:0];
            end
            if (misc_wr && idx == LVL_W'(MISC_ENABLE)) begin
                enable <= reg_wdata[NUM_LEVELS-1:0];
            end
            if (underflow_any) begin
                err_flag <= 1'b1;
            end else if (misc_wr && idx == LVL_W'(MISC_ERROR) && reg_wdata[0]) begin
                err_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RGN_COUNT: begin
                if (idx_ok) reg_rdata = DATA_W'(cnt_vec[idx]);
            end
            RGN_THRESH: begin
                if (idx_ok) reg_rdata = DATA_W'(thr_vec[idx]);
            end
            RGN_MISC: begin
                if (idx == LVL_W'(MISC_TOTAL))       reg_rdata = DATA_W'(tot);
                else if (idx == LVL_W'(MISC_ENABLE)) reg_rdata = DATA_W'(enable);
                else if (idx == LVL_W'(MISC_STATUS)) reg_rdata = DATA_W'(stat_vec);
                else if (idx == LVL_W'(MISC_ERROR))  reg_rdata = DATA_W'(err_flag);
            end
            RGN_SPARE: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qdepth_irq.sv
module qdepth_irq
    import qdepth_pkg::*;
#(
    parameter  int NUM_LEVELS = 8,
    parameter  int CNT_W      = 32,
    parameter  int TOT_W      = 32,
    localparam int LVL_W      = $clog2(NUM_LEVELS),
    localparam int ADDR_W     = LVL_W + 2,
    localparam int DATA_W     = widest(CNT_W, TOT_W, NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [LVL_W-1:0]  enq_level,
    input  logic              deq_valid,
    input  logic [LVL_W-1:0]  deq_level,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [NUM_LEVELS-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_LEVELS-1:0][CNT_W-1:0] thr_vec;
    logic [NUM_LEVELS-1:0]            stat_vec;
    logic [NUM_LEVELS-1:0]            clr_vec;
    logic [NUM_LEVELS-1:0]            enable;
    logic [NUM_LEVELS-1:0]            dec_taken_vec;
    logic [NUM_LEVELS-1:0]            underflow_vec;
    logic [NUM_LEVELS-1:0]            enq_hot;
    logic [NUM_LEVELS-1:0]            deq_hot;
    logic [TOT_W-1:0]                 tot_q;
    logic                             err_flag;

    always_comb begin
        enq_hot = '0;
        deq_hot = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            enq_hot[i] = enq_valid && (int'(enq_level) == i);
            deq_hot[i] = deq_valid && (int'(deq_level) == i);
        end
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        qdepth_level #(.CNT_W(CNT_W)) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (enq_hot[g]),
            .dec       (deq_hot[g]),
            .thr       (thr_vec[g]),
            .clr_stat  (clr_vec[g]),
            .cnt       (cnt_vec[g]),
            .stat      (stat_vec[g]),
            .dec_taken (dec_taken_vec[g]),
            .underflow (underflow_vec[g])
        );
    end

    qdepth_total #(.TOT_W(TOT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (|enq_hot),
        .dec   (|dec_taken_vec),
        .tot   (tot_q)
    );

    qdepth_regs #(
        .NUM_LEVELS (NUM_LEVELS),
        .CNT_W      (CNT_W),
        .TOT_W      (TOT_W),
        .LVL_W      (LVL_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wen       (reg_wen),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .cnt_vec       (cnt_vec),
        .tot           (tot_q),
        .stat_vec      (stat_vec),
        .underflow_any (|underflow_vec),
        .thr_vec       (thr_vec),
        .enable        (enable),
        .clr_vec       (clr_vec),
        .err_flag      (err_flag),
        .reg_rdata     (reg_rdata)
    );

    assign irq = |(stat_vec & enable);

endmodule

// File: rtl/qdepth_irq_chk.sv
module qdepth_irq_chk #(
    parameter int NUM_LEVELS = 8,
    parameter int CNT_W      = 32,
    parameter int TOT_W      = 32,
    parameter int LVL_W      = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             enq_valid,
    input logic [LVL_W-1:0]                 enq_level,
    input logic                             deq_valid,
    input logic [LVL_W-1:0]                 deq_level,
    input logic [NUM_LEVELS-1:0][CNT_W-1:0] cnt_vec,
    input logic [TOT_W-1:0]                 tot,
    input logic [NUM_LEVELS-1:0]            stat_vec,
    input logic                             err_flag
);
    logic [TOT_W-1:0] sum;
    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_LEVELS; i++) sum = sum + TOT_W'(cnt_vec[i]);
    end

    // R6: combined depth tracks the sum of the per-level depths
    assert_total_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tot == sum);

    // R4: a same-level enqueue/dequeue pair leaves every depth as it was
    assert_pair_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && deq_valid && enq_level == deq_level) |=> $stable(cnt_vec));

    // R5: a dequeue on an empty level raises the error flag
    assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !(enq_valid && enq_level == deq_level)
         && cnt_vec[deq_level] == '0) |=> err_flag);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_chk
        // R2 and R3: a depth moves by exactly one step
        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_vec[g] != $past(cnt_vec[g])) |->
            (cnt_vec[g] == $past(cnt_vec[g]) + CNT_W'(1) ||
             cnt_vec[g] == $past(cnt_vec[g]) - CNT_W'(1)));

        // R7: a status bit rises only together with a depth change
        assert_status_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_vec[g]) |-> (cnt_vec[g] != $past(cnt_vec[g])));
    end

endmodule

bind qdepth_irq qdepth_irq_chk #(
    .NUM_LEVELS (NUM_LEVELS),
    .CNT_W      (CNT_W),
    .TOT_W      (TOT_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_level (enq_level),
    .deq_valid (deq_valid),
    .deq_level (deq_level),
    .cnt_vec   (cnt_vec),
    .tot       (tot_q),
    .stat_vec  (stat_vec),
    .err_flag  (err_flag)
);

// File: tb/tb_qdepth_irq.sv
module tb_qdepth_irq;
    localparam int PERIOD = 10;
    localparam int NL = 8;
    localparam int CW = 6;
    localparam int TW = 9;
    localparam int AW = 5;
    localparam int DW = 9;

    localparam logic [AW-1:0] A_TOTAL  = 5'd16;
    localparam logic [AW-1:0] A_ENABLE = 5'd17;
    localparam logic [AW-1:0] A_STATUS = 5'd18;
    localparam logic [AW-1:0] A_ERROR  = 5'd19;

    // {enq_v, enq_lvl, deq_v, deq_lvl, check_lvl, exp_depth, exp_total}
    localparam int NVEC = 12;
    localparam logic [24:0] VECS [NVEC] = '{
        {1'b1, 3'd2, 1'b0, 3'd0, 3'd2, 6'd1, 8'd1},
        {1'b1, 3'd2, 1'b0, 3'd0, 3'd2, 6'd2, 8'd2},
        {1'b1, 3'd5, 1'b0, 3'd0, 3'd5, 6'd1, 8'd3},
        {1'b1, 3'd2, 1'b1, 3'd5, 3'd5, 6'd0, 8'd3},
        {1'b0, 3'd0, 1'b0, 3'd0, 3'd2, 6'd3, 8'd3},
        {1'b1, 3'd2, 1'b1, 3'd2, 3'd2, 6'd3, 8'd3},
        {1'b0, 3'd0, 1'b1, 3'd0, 3'd0, 6'd0, 8'd3},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'd2, 6'd2, 8'd2},
        {1'b1, 3'd7, 1'b1, 3'd0, 3'd7, 6'd1, 8'd3},
        {1'b1, 3'd0, 1'b1, 3'd0, 3'd0, 6'd0, 8'd3},
        {1'b0, 3'd0, 1'b1, 3'd7, 3'd7, 6'd0, 8'd2},
        {1'b0, 3'd0, 1'b1, 3'd2, 3'd2, 6'd1, 8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic [2:0]    enq_level = '0;
    logic          deq_valid = 1'b0;
    logic [2:0]    deq_level = '0;
    logic          reg_wen = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    qdepth_irq #(.NUM_LEVELS(NL), .CNT_W(CW), .TOT_W(TW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_level (enq_level),
        .deq_valid (deq_valid),
        .deq_level (deq_level),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic [2:0] el,
                        input logic dv, input logic [2:0] dl,
                        input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd);
        @(negedge clk);
        enq_valid = ev; enq_level = el;
        deq_valid = dv; deq_level = dl;
        reg_wen = we; reg_addr = wa; reg_wdata = wd;
        @(negedge clk);
        enq_valid = 1'b0; deq_valid = 1'b0; reg_wen = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, a, d);
    endtask

    task automatic enq(input logic [2:0] l);
        step(1'b1, l, 1'b0, 3'd0, 1'b0, '0, '0);
    endtask

    task automatic deq(input logic [2:0] l);
        step(1'b0, 3'd0, 1'b1, l, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state across every mapped register
        for (int a = 0; a < 20; a++) begin
            rd(AW'(a), v);
            check("R1 reset read", v, 0);
        end
        check("R1 reset irq", int'(irq), 0);

        // R2 R3 R4 R5 R6: vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [24:0] t;
            t = VECS[i];
            step(t[24], t[23:21], t[20], t[19:17], 1'b0, '0, '0);
            rd(AW'(t[16:14]), v);
            check("R2 R3 R4 R5 level depth", v, int'(t[13:8]));
            rd(A_TOTAL, v);
            check("R6 combined depth", v, int'(t[7:0]));
        end

        // R5: sticky flag after empty dequeues, then write-one clear
        rd(A_ERROR, v);
        check("R5 underflow flag set", v, 1);
        wr(A_ERROR, 9'd1);
        rd(A_ERROR, v);
        check("R5 underflow flag cleared", v, 0);

        // R7: levels 5 and 7 fell onto threshold 0 during the walk
        rd(A_STATUS, v);
        check("R7 decrement onto threshold", v, 'hA0);
        wr(A_STATUS, 9'hFF);
        rd(A_STATUS, v);
        check("R8 clear all status", v, 0);

        // R7 R10: increment onto threshold
        wr(5'd11, 9'd2);
        wr(A_ENABLE, 9'h08);
        enq(3'd3);
        rd(A_STATUS, v);
        check("R7 below threshold no status", v, 0);
        check("R10 irq low", int'(irq), 0);
        enq(3'd3);
        rd(A_STATUS, v);
        check("R7 arrival sets status", v, 'h08);
        check("R10 irq high", int'(irq), 1);

        // R8: zero write no effect, one write clears
        wr(A_STATUS, 9'h00);
        rd(A_STATUS, v);
        check("R8 zero write keeps status", v, 'h08);
        wr(A_STATUS, 9'h08);
        rd(A_STATUS, v);
        check("R8 one write clears status", v, 0);
        check("R10 irq after clear", int'(irq), 0);

        // R7: threshold write equal to current depth does not set
        wr(5'd11, 9'd2);
        rd(A_STATUS, v);
        check("R7 threshold write no status", v, 0);

        // R4: same-level pair at the threshold sets nothing
        step(1'b1, 3'd3, 1'b1, 3'd3, 1'b0, '0, '0);
        rd(5'd3, v);
        check("R4 pair depth", v, 2);
        rd(A_STATUS, v);
        check("R4 pair no status", v, 0);

        // R7: pass above, come back down onto threshold
        enq(3'd3);
        rd(A_STATUS, v);
        check("R7 past threshold no status", v, 0);
        deq(3'd3);
        rd(A_STATUS, v);
        check("R7 dequeue onto threshold", v, 'h08);

        // R9: set and clear in the same cycle
        wr(A_STATUS, 9'h08);
        deq(3'd3);
        step(1'b1, 3'd3, 1'b0, 3'd0, 1'b1, A_STATUS, 9'h08);
        rd(A_STATUS, v);
        check("R9 set wins over clear", v, 'h08);

        // R10: enable gating
        wr(A_STATUS, 9'h08);
        wr(5'd12, 9'd1);
        enq(3'd4);
        rd(A_STATUS, v);
        check("R7 level 4 status", v, 'h10);
        check("R10 disabled level no irq", int'(irq), 0);
        wr(A_ENABLE, 9'h10);
        check("R10 enabling raises irq", int'(irq), 1);

        // R6 R11: totals and spare region
        rd(A_TOTAL, v);
        check("R6 final combined depth", v, 4);
        rd(5'd12, v);
        check("R11 threshold readback", v, 1);
        rd(5'd24, v);
        check("R11 spare region reads zero", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule